// File: doc/BRIEF.md
# Byte-Order Buffer Serializer

This block sits between a memory fetch path and a serial transmitter. It accepts 32-bit words from a data buffer over a valid/ready handshake. It returns them one byte at a time over a second valid/ready handshake, in an order chosen by a 2-bit ordering code. The ordering code and a port-width flag are sampled only when a buffer-start strobe is pulsed. A buffer that is already streaming therefore keeps its byte order even if software rewrites the code. The new setting applies from the next buffer.

Three orders exist:
- **Big-endian (code 1x):** each word is sent from its most significant byte down to its least significant byte.
- **Swapped (code 00):** each word is sent from its least significant byte up. This order is only meaningful on a 32-bit memory port.
- **Double-word little-endian (code 01):** two consecutive words form a 64-bit unit, and the first word received is the upper half. All eight bytes are sent from the least significant byte of that unit up.

If the swapped code is captured together with a 64-bit port flag, the block raises a configuration-error output and falls back to big-endian order.

Top module: `byte_order_ser`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and cfg_err is 0. The captured setting is big-endian on a 32-bit port, so words sent before any bd_start are serialized most significant byte first.
- R2: With a captured code of 10 or 11, word w is sent as w[31:24], w[23:16], w[15:8], w[7:0].
- R3: With captured code 00 and port64 captured as 0, word w is sent as w[7:0], w[15:8], w[23:16], w[31:24].
- R4: With captured code 01, words a then b form the unit {a,b}. It is sent as b[7:0], b[15:8], b[23:16], b[31:24], a[7:0], a[15:8], a[23:16], a[31:24].
- R5: With captured code 01, out_valid stays 0 and in_ready stays 1 after the first word of a pair is accepted, until the second word is accepted.
- R6: order_sel and port64 are sampled only in a cycle where bd_start is 1. Changing them at any other time alters neither the byte order nor cfg_err.
- R7: With captured code 00 and port64 captured as 1, cfg_err is 1 and each word is sent in the big-endian order of R2.
- R8: Once a word (or the second word of a pair) is accepted, in_ready is 0 until the last of its bytes has been taken. in_ready is 1 again in the cycle after that.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bd_start | input | 1 | Buffer-start strobe; captures order_sel and port64 |
| order_sel | input | 2 | Ordering code: 1x big-endian, 00 swapped, 01 double-word little-endian |
| port64 | input | 1 | 1 when the memory port is 64 bits wide |
| in_word | input | WORD_W | Data word from the buffer |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Block can accept a word |
| out_byte | output | 8 | Byte toward the transmitter |
| out_valid | output | 1 | out_byte is valid |
| out_ready | input | 1 | Transmitter takes out_byte |
| cfg_err | output | 1 | Swapped code captured with a 64-bit port |

## Verification
Every captured setting receives random words: both big-endian codes, swapped on a 32-bit port, double-word mode on each port width, and the illegal swapped/64-bit pair. Each setting is also run under random gaps on the input and random stalls on the output. This separates per-word reversal from whole-unit reversal, and it shows whether the first word of a pair lands in the upper half. Streams are also run with the ordering inputs rewritten mid-buffer or without a start strobe. These runs show that only the strobe moves the captured setting. A fixed pattern such as 01020304 makes any lane mix-up visible at once.

// File: rtl/byte_order_ser.sv
module byte_order_ser #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bd_start,
  input  logic [1:0]        order_sel,
  input  logic              port64,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              cfg_err
);
  localparam int NB = WORD_W / 8;
  localparam int KW = $clog2(2 * NB);
  localparam int AW = KW + 3;

  logic [1:0]          mode_q;
  logic                port_q;
  logic [2*WORD_W-1:0] buf_q;
  logic                half_q;
  logic                busy_q;
  logic [KW-1:0]       k_q;

  wire          dw    = (mode_q == 2'b01);
  wire          rev   = dw || (mode_q == 2'b00 && !port_q);
  wire [KW-1:0] last  = dw ? KW'(2*NB-1) : KW'(NB-1);
  wire [KW-1:0] sel   = rev ? k_q : KW'(NB-1) - k_q;
  wire [AW-1:0] base  = {sel, 3'b000};
  wire          in_fire  = in_valid && in_ready;
  wire          out_fire = out_valid && out_ready;

  assign cfg_err   = (mode_q == 2'b00) && port_q;
  assign in_ready  = !busy_q;
  assign out_valid = busy_q;
  assign out_byte  = buf_q[base +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'b10;
      port_q <= 1'b0;
      buf_q  <= '0;
      half_q <= 1'b0;
      busy_q <= 1'b0;
      k_q    <= '0;
    end else begin
      if (in_fire) begin
        k_q <= '0;
        if (dw && !half_q) begin
          buf_q[2*WORD_W-1:WORD_W] <= in_word;
          half_q <= 1'b1;
        end else begin
          buf_q[WORD_W-1:0] <= in_word;
          half_q <= 1'b0;
          busy_q <= 1'b1;
        end
      end
      if (out_fire) begin
        if (k_q == last) begin
          busy_q <= 1'b0;
          k_q    <= '0;
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
      if (bd_start) begin
        mode_q <= order_sel;
        port_q <= port64;
        half_q <= 1'b0;
      end
    end
  end

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  // R8
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && k_q == last) |=> !in_ready);

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bd_start |=> $stable(mode_q) && $stable(port_q));

  // R5
  dw_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dw && half_q |-> !out_valid && in_ready);

  // R4
  dw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dw && out_valid && k_q == '0 |-> out_byte == buf_q[7:0]);

  // R7
  err_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && out_valid && k_q == '0 |-> out_byte == buf_q[WORD_W-1 -: 8]);
endmodule

// File: tb/byte_order_ser_test.sv
`timescale 1ns/1ps
module byte_order_ser_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bd_start;
  logic [1:0]  order_sel;
  logic        port64;
  logic [31:0] in_word;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        out_ready;
  logic        cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0]  cur_m = 2'b10;
  logic        cur_p = 1'b0;
  logic [31:0] wq [16];
  logic [7:0]  eq [128];
  logic [7:0]  gq [128];

  always #2 clk = ~clk;

  byte_order_ser #(.WORD_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .bd_start(bd_start), .order_sel(order_sel),
    .port64(port64), .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
    .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int build_exp(input int nw, input logic [1:0] m, input logic p);
    int n = 0;
    if (m == 2'b01) begin
      for (int i = 0; i < nw; i += 2) begin
        logic [63:0] d = {wq[i], wq[i+1]};
        for (int k = 0; k < 8; k++) begin eq[n] = d[8*k +: 8]; n++; end
      end
    end else begin
      for (int i = 0; i < nw; i++)
        for (int k = 0; k < 4; k++) begin
          eq[n] = (m == 2'b00 && !p) ? wq[i][8*k +: 8] : wq[i][8*(3-k) +: 8];
          n++;
        end
    end
    return n;
  endfunction

  task automatic sender(input int nw);
    for (int i = 0; i < nw; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      in_word = wq[i];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (cur_m == 2'b01 && (i % 2) == 0) begin
        chk("R5 out_valid after first half", out_valid, 0);
        chk("R5 in_ready after first half", in_ready, 1);
      end else begin
        chk("R8 in_ready after accept", in_ready, 0);
      end
      if (i == nw / 2) begin
        order_sel = 2'($urandom);
        port64 = 1'($urandom);
      end
    end
  endtask

  task automatic receiver(input int ne);
    int got = 0;
    logic held = 1'b0;
    logic [7:0] hb = '0;
    while (got < ne) begin
      @(negedge clk);
      if (held) chk("R9 byte held under stall", out_byte, hb);
      out_ready = ($urandom % 4) != 0;
      held = out_valid && !out_ready;
      hb = out_byte;
      if (out_valid && out_ready) begin
        gq[got] = out_byte;
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_buf(input logic [1:0] m, input logic p, input int nw, input logic strobe);
    int ne;
    string tag;
    if (strobe) begin
      order_sel = m; port64 = p; bd_start = 1'b1;
      @(negedge clk);
      bd_start = 1'b0;
      cur_m = m; cur_p = p;
    end else begin
      order_sel = m; port64 = p;
      @(negedge clk);
    end
    chk(strobe ? "R7 cfg_err after capture" : "R6 cfg_err without strobe",
        cfg_err, (cur_m == 2'b00) && cur_p);
    for (int i = 0; i < nw; i++) wq[i] = (i == 0) ? 32'h01020304 : $urandom;
    ne = build_exp(nw, cur_m, cur_p);
    if (cur_m == 2'b01) tag = "R4";
    else if (cur_m == 2'b00 && !cur_p) tag = "R3";
    else if (cur_m == 2'b00) tag = "R7";
    else tag = "R2";
    if (!strobe) tag = {tag, "/R6"};
    fork
      sender(nw);
      receiver(ne);
    join
    for (int i = 0; i < ne; i++) chk(tag, gq[i], eq[i]);
    chk("R8 in_ready after last byte", in_ready, 1);
    chk("R8 no extra bytes", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; bd_start = 1'b0; order_sel = 2'b00; port64 = 1'b0;
    in_word = '0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 cfg_err", cfg_err, 0);
    run_buf(2'b00, 1'b0, 3, 1'b0);   // R1: default big-endian
    run_buf(2'b11, 1'b0, 4, 1'b1);
    run_buf(2'b10, 1'b0, 2, 1'b1);
    run_buf(2'b00, 1'b0, 5, 1'b1);
    run_buf(2'b01, 1'b0, 6, 1'b1);
    run_buf(2'b00, 1'b1, 4, 1'b1);
    run_buf(2'b01, 1'b0, 4, 1'b0);   // R6: no strobe, keeps 00/64
    run_buf(2'b01, 1'b1, 4, 1'b1);
    run_buf(2'b10, 1'b1, 2, 1'b1);
    for (int r = 0; r < 10; r++)
      run_buf(2'($urandom), 1'($urandom), 2 * (1 + $urandom % 5), 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule